// File: doc/BRIEF.md
# USB Port Line Control

This block is the control register and line-drive stage that sits between a USB device's serial engine and its transceiver. One byte-wide register holds a port enable, a speed select, a low-power request and a two-bit line-force selector. The register is written and read over a simple byte bus with an address, a write strobe, write data and combinational read data.

In normal operation the serial engine's D+ and D− levels pass through to the transceiver, registered once. Its output-enable passes only while the port is enabled. When the force selector is non-zero, the stage ignores the engine and drives a fixed SE0, K or J state with the output-enable held on. This lets firmware signal resume, reset or a chosen idle level by hand. The speed indication and the transceiver low-power request follow the register directly. Suspend is raised only when low power is requested while the port is disabled.

Top module: `usb_port_linectl`

## Requirements
- R1: After synchronous reset the control register reads 0x00, and `low_speed`, `xcvr_lowpwr`, `suspend`, `usb_dp`, `usb_dm` and `usb_oe` are all 0.
- R2: A write strobe with `bus_addr == CTRL_ADDR` stores the fields on that clock edge: enable in bit 0, force selector in bits 4:3, speed in bit 5 and low power in bit 6. A read at `CTRL_ADDR` returns them in the same positions. Bits 1, 2 and 7 always read 0.
- R3: A write to any other address leaves the register unchanged. A read of any other address returns 0x00.
- R4: `low_speed` equals bit 5: 0 means full speed (12 Mb/s) and 1 means low speed (1.5 Mb/s).
- R5: `xcvr_lowpwr` equals bit 6.
- R6: `suspend` is 1 exactly when bit 6 is 1 and bit 0 is 0.
- R7: With force selector 00, `usb_dp` and `usb_dm` equal the engine's `eng_dp` and `eng_dm` one clock later. `usb_oe` equals `eng_oe` AND the enable bit, one clock later.
- R8: With force selector 01, the next clock drives SE0: `usb_dp` = 0 and `usb_dm` = 0.
- R9: With force selector 10, the next clock drives the K state: `usb_dp` = 0 and `usb_dm` = 1.
- R10: With force selector 11, the next clock drives the J state: `usb_dp` = 1 and `usb_dm` = 0.
- R11: With any non-zero force selector, `usb_oe` is 1 on the next clock, whatever the values of `eng_oe` and the enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| eng_dp | input | 1 | D+ level from serial engine |
| eng_dm | input | 1 | D− level from serial engine |
| eng_oe | input | 1 | Output-enable from serial engine |
| usb_dp | output | 1 | D+ drive to transceiver |
| usb_dm | output | 1 | D− drive to transceiver |
| usb_oe | output | 1 | Line output-enable to transceiver |
| low_speed | output | 1 | 1 = low speed, 0 = full speed |
| xcvr_lowpwr | output | 1 | Transceiver low-power request |
| suspend | output | 1 | Suspend indication |

## Verification
Some rules are checked by assertions on every cycle. These are the one-cycle pass-through of engine levels in normal mode, the fixed SE0, K and J levels with a held output-enable while forcing, the field capture on a matching write, the stability of the register across writes to other addresses, and the rule that suspend never appears without low power. Other behaviour shows up only in the bench's scenarios. This covers the reset values seen at the ports and the read-back encoding, including the zero bits and zero reads of foreign addresses. It also covers the enable gating of the engine's output-enable, and forcing overriding an engine and enable that are both off.

// File: rtl/usb_linectl_pkg.sv
package usb_linectl_pkg;

    localparam int BUS_W   = 8;
    localparam int EN_BIT  = 0;
    localparam int FRC_LO  = 3;
    localparam int FRC_HI  = FRC_LO + 1;
    localparam int SPD_BIT = 5;
    localparam int LP_BIT  = 6;

    typedef enum logic [1:0] {
        FRC_NONE = 2'b00,
        FRC_SE0  = 2'b01,
        FRC_K    = 2'b10,
        FRC_J    = 2'b11
    } force_e;

    typedef struct packed {
        logic   lowpwr;
        logic   low_spd;
        force_e force_sel;
        logic   en;
    } ctrl_t;

    typedef struct packed {
        logic dp;
        logic dm;
        logic oe;
    } line_t;

    localparam ctrl_t CTRL_RST = '{lowpwr: 1'b0, low_spd: 1'b0, force_sel: FRC_NONE, en: 1'b0};
    localparam line_t LINE_RST = '{dp: 1'b0, dm: 1'b0, oe: 1'b0};

    function automatic ctrl_t ctrl_from_byte(input logic [BUS_W-1:0] b);
        ctrl_t c;
        c.en        = b[EN_BIT];
        c.force_sel = force_e'(b[FRC_HI:FRC_LO]);
        c.low_spd   = b[SPD_BIT];
        c.lowpwr    = b[LP_BIT];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_to_byte(input ctrl_t c);
        logic [BUS_W-1:0] b;
        b                = '0;
        b[EN_BIT]        = c.en;
        b[FRC_HI:FRC_LO] = c.force_sel;
        b[SPD_BIT]       = c.low_spd;
        b[LP_BIT]        = c.lowpwr;
        return b;
    endfunction

    function automatic line_t forced_line(input force_e f);
        line_t l;
        l.oe = 1'b1;
        case (f)
            FRC_K:   begin l.dp = 1'b0; l.dm = 1'b1; end
            FRC_J:   begin l.dp = 1'b1; l.dm = 1'b0; end
            default: begin l.dp = 1'b0; l.dm = 1'b0; end
        endcase
        return l;
    endfunction

endpackage

// File: rtl/linectl_regs.sv
module linectl_regs
    import usb_linectl_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(5)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output ctrl_t             ctrl_q
);

    logic hit;
    assign hit = (bus_addr == CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RST;
        else if (bus_wr && hit)
            ctrl_q <= ctrl_from_byte(bus_wdata);
    end

    always_comb begin
        bus_rdata = '0;
        if (hit)
            bus_rdata = ctrl_to_byte(ctrl_q);
    end

    AST_CTRL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit) |=> (ctrl_q == ctrl_from_byte($past(bus_wdata)))); // R2

    AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !hit) |=> $stable(ctrl_q)); // R3

endmodule

// File: rtl/linectl_mode.sv
module linectl_mode
    import usb_linectl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    output logic  low_speed,
    output logic  xcvr_lowpwr,
    output logic  suspend
);

    assign low_speed   = ctrl.low_spd;
    assign xcvr_lowpwr = ctrl.lowpwr;
    assign suspend     = ctrl.lowpwr & ~ctrl.en;

    AST_SUSPEND_NEEDS_LP: assert property (@(posedge clk) disable iff (rst)
        suspend |-> xcvr_lowpwr); // R6

endmodule

// File: rtl/linectl_drive.sv
module linectl_drive
    import usb_linectl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  line_t eng,
    output line_t line_q
);

    line_t nxt;
    logic  armed;

    always_comb begin
        if (ctrl.force_sel == FRC_NONE) begin
            nxt.dp = eng.dp;
            nxt.dm = eng.dm;
            nxt.oe = eng.oe & ctrl.en;
        end else begin
            nxt = forced_line(ctrl.force_sel);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= LINE_RST;
            armed  <= 1'b0;
        end else begin
            line_q <= nxt;
            armed  <= 1'b1;
        end
    end

    AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(ctrl.force_sel) == FRC_NONE) |->
            (line_q.dp == $past(eng.dp) && line_q.dm == $past(eng.dm))); // R7

    AST_FORCE_SE0: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(ctrl.force_sel) == FRC_SE0) |-> (!line_q.dp && !line_q.dm)); // R8

    AST_FORCE_K: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(ctrl.force_sel) == FRC_K) |-> (!line_q.dp && line_q.dm)); // R9

    AST_FORCE_J: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(ctrl.force_sel) == FRC_J) |-> (line_q.dp && !line_q.dm)); // R10

    AST_FORCE_OE: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(ctrl.force_sel) != FRC_NONE) |-> line_q.oe); // R11

endmodule

// File: rtl/usb_port_linectl.sv
module usb_port_linectl
    import usb_linectl_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(5)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              eng_dp,
    input  logic              eng_dm,
    input  logic              eng_oe,
    output logic              usb_dp,
    output logic              usb_dm,
    output logic              usb_oe,
    output logic              low_speed,
    output logic              xcvr_lowpwr,
    output logic              suspend
);

    ctrl_t ctrl;
    line_t eng_line;
    line_t drv_line;

    assign eng_line = '{dp: eng_dp, dm: eng_dm, oe: eng_oe};

    linectl_regs #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl_q    (ctrl)
    );

    linectl_mode u_mode (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .low_speed   (low_speed),
        .xcvr_lowpwr (xcvr_lowpwr),
        .suspend     (suspend)
    );

    linectl_drive u_drive (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (ctrl),
        .eng    (eng_line),
        .line_q (drv_line)
    );

    assign usb_dp = drv_line.dp;
    assign usb_dm = drv_line.dm;
    assign usb_oe = drv_line.oe;

endmodule

// File: tb/usb_port_linectl_bench.sv
module usb_port_linectl_bench;

    localparam int         CLK_PERIOD = 10;
    localparam int         AW         = 8;
    localparam logic [7:0] CADDR      = 8'h05;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          eng_dp = 1'b0, eng_dm = 1'b0, eng_oe = 1'b0;
    logic          usb_dp, usb_dm, usb_oe, low_speed, xcvr_lowpwr, suspend;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_port_linectl #(.ADDR_W(AW), .CTRL_ADDR(CADDR)) u_usb_port_linectl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_dp(eng_dp), .eng_dm(eng_dm), .eng_oe(eng_oe),
        .usb_dp(usb_dp), .usb_dm(usb_dm), .usb_oe(usb_oe),
        .low_speed(low_speed), .xcvr_lowpwr(xcvr_lowpwr), .suspend(suspend)
    );

    task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = CADDR;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = CADDR;
    endtask

    function automatic logic [7:0] lines();
        return {5'b0, usb_dp, usb_dm, usb_oe};
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        rd(CADDR, v);
        chk("R1", "ctrl after reset", v, 8'h00);
        chk("R1", "mode outs after reset", {5'b0, low_speed, xcvr_lowpwr, suspend}, 8'h00);
        chk("R1", "lines after reset", lines(), 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(CADDR, 8'hFF);
        rd(CADDR, v);
        chk("R2", "all-ones write readback", v, 8'h79);
        wr(CADDR, 8'h09);
        rd(CADDR, v);
        chk("R2", "en+force01 readback", v, 8'h09);
        wr(CADDR, 8'h00);
    endtask

    task automatic t_stray();
        logic [7:0] v;
        wr(CADDR, 8'h21);
        wr(8'h06, 8'h5E);
        rd(CADDR, v);
        chk("R3", "ctrl after foreign write", v, 8'h21);
        rd(8'h06, v);
        chk("R3", "foreign read", v, 8'h00);
        chk("R4", "low speed after foreign write", {7'b0, low_speed}, 8'h01);
        wr(CADDR, 8'h00);
    endtask

    task automatic t_power();
        wr(CADDR, 8'h20);
        chk("R4", "speed bit set", {7'b0, low_speed}, 8'h01);
        wr(CADDR, 8'h00);
        chk("R4", "speed bit clear", {7'b0, low_speed}, 8'h00);
        wr(CADDR, 8'h40);
        chk("R5", "lowpwr", {7'b0, xcvr_lowpwr}, 8'h01);
        chk("R6", "suspend lp&!en", {7'b0, suspend}, 8'h01);
        wr(CADDR, 8'h41);
        chk("R6", "no suspend lp&en", {7'b0, suspend}, 8'h00);
        chk("R5", "lowpwr with en", {7'b0, xcvr_lowpwr}, 8'h01);
        wr(CADDR, 8'h00);
        chk("R6", "no suspend idle", {7'b0, suspend}, 8'h00);
    endtask

    task automatic t_normal();
        wr(CADDR, 8'h01);
        @(negedge clk);
        eng_dp = 1'b1; eng_dm = 1'b0; eng_oe = 1'b1;
        @(negedge clk);
        chk("R7", "pass J en", lines(), 8'h05);
        eng_dp = 1'b0; eng_dm = 1'b1;
        @(negedge clk);
        chk("R7", "pass K en", lines(), 8'h03);
        wr(CADDR, 8'h00);
        @(negedge clk);
        chk("R7", "oe gated by disable", lines(), 8'h02);
    endtask

    task automatic t_force();
        eng_dp = 1'b1; eng_dm = 1'b1; eng_oe = 1'b0;
        wr(CADDR, 8'h08);
        @(negedge clk);
        chk("R8", "SE0", lines(), 8'h01);
        wr(CADDR, 8'h10);
        @(negedge clk);
        chk("R9", "K state", lines(), 8'h03);
        chk("R11", "oe held disabled eng off", {7'b0, usb_oe}, 8'h01);
        wr(CADDR, 8'h18);
        @(negedge clk);
        chk("R10", "J state", lines(), 8'h05);
        wr(CADDR, 8'h00);
        @(negedge clk);
        chk("R7", "release to engine", lines(), 8'h06);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        bus_addr = CADDR;
        @(negedge clk);
        t_reset();
        t_regs();
        t_stray();
        t_power();
        t_normal();
        t_force();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule